// File: doc/BRIEF.md
# Bus-Tracking Memory Address Unit

This block sits inside each memory device of a processor system that has no address bus. The processor issues a 5-bit command code for each bus cycle and every memory device listens. Each device keeps its own mirror of the two program counters (PC0, PC1) and the two data counters (DC0, DC1). It applies the same update as the processor, so every copy stays in step. Only the device whose address window holds the relevant counter drives the shared 8-bit data bus. All other devices leave it released and still apply the update, using the byte another agent placed on the bus.

A command is presented with a valid strobe and taken on a rising clock edge. The cycle after that edge is the execute cycle. In it the device drives the bus if it owns the read, or it listens. At the end of the execute cycle, on the next rising edge, the mirrors update. A controller with three states handles this:
- ST_IDLE: no command is executing.
- ST_DRIVE: an owned read is executing and the device is driving the bus.
- ST_LISTEN: any other accepted command is executing.

The controller has these transitions:
- accept-owned goes to ST_DRIVE.
- accept-other goes to ST_LISTEN.
- complete goes back to ST_IDLE.

Both accepts can be taken from any state, so back-to-back commands run with no idle cycle. The device holds a small read-only array. It also reports a cycle-length tag for the executing command.

Top module: `mem_addr_tracker`

## Requirements
- R1: After reset all four mirrors read 0x0000, bus_drive is 0, long_cyc is 0 and the data bus is released.
- R2: A code is taken only on a rising edge with cmd_valid high. It executes in the next cycle and its register update appears after the rising edge that ends that cycle. A new code may be taken on that same edge. With cmd_valid low, bus values and codes change nothing.
- R3: Code 0x00 (fetch): the owner of PC0 drives the array byte at PC0. Every device then increments PC0, wrapping from 0xFFFF to 0x0000.
- R4: Code 0x01 (relative jump): the owner of PC0 drives the array byte at PC0. Every device then adds the bus byte to PC0 as a signed two's-complement offset.
- R5: Code 0x02 (data read): the owner of DC0 drives the array byte at DC0. Every device then increments DC0 modulo 2^16.
- R6: Codes 0x14, 0x15 and 0x16 copy the bus byte into bits 15:8 of PC0, PC1 and DC0 respectively. The other mirrors stay unchanged.
- R7: Codes 0x17, 0x18 and 0x19 copy the bus byte into bits 7:0 of PC0, PC1 and DC0 respectively. The other mirrors stay unchanged.
- R8: Code 0x1D exchanges DC0 and DC1 when HAS_DC1 is 1. When HAS_DC1 is 0 it does nothing.
- R9: The PC0 owner drives bits 7:0 of PC0 for code 0x1E and bits 15:8 for code 0x1F. No mirror changes.
- R10: A counter is owned when BASE <= counter < BASE+SIZE (defaults 0x0400 and 64). The rule is checked at both edges of the window. Without ownership bus_drive stays 0 and the update still uses the external bus byte.
- R11: All other codes (0x03 to 0x13, 0x1A, 0x1B, 0x1C) leave every mirror unchanged and the bus released.
- R12: The array byte at address A equals ((A - BASE) * 37 + 11) mod 256.
- R13: During the execute cycle long_cyc is 0 for codes 0x00, 0x03, 0x04, 0x0D, 0x1C and 0x1D, and 1 for every other code. It is 0 whenever no command executes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 5 | Command code for the cycle |
| cmd_valid | input | 1 | Marks cmd_code as a new bus cycle |
| data_bus | inout | 8 | Shared bidirectional data bus |
| bus_drive | output | 1 | High while this device drives data_bus |
| long_cyc | output | 1 | Cycle-length tag of the executing command |
| pc0_o | output | 16 | Mirror of PC0 |
| pc1_o | output | 16 | Mirror of PC1 |
| dc0_o | output | 16 | Mirror of DC0 |
| dc1_o | output | 16 | Mirror of DC1 |

## Verification
The assertions rest on the following assumptions about the inputs:
- Exactly one bus agent drives the data bus during an execute cycle whenever the code needs a byte.
- cmd_code holds a defined value whenever cmd_valid is high.
- The parameters describe a window that does not run past 0xFFFF.

The directed tasks stay within these limits. The bench puts a byte on the bus only in execute cycles where the requirements say the device stays silent. It presents every code together with the strobe. It leaves the default window in place, and it places counters just inside and just outside both ends of that window.

// File: rtl/mat_pkg.sv
package mat_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_LISTEN
    } bus_state_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PC0_MEM,
        SRC_DC0_MEM,
        SRC_PC0_LO,
        SRC_PC0_HI
    } rd_src_e;

    typedef enum logic [3:0] {
        UPD_NONE,
        UPD_PC0_INC,
        UPD_PC0_REL,
        UPD_DC0_INC,
        UPD_PC0_HI,
        UPD_PC1_HI,
        UPD_DC0_HI,
        UPD_PC0_LO,
        UPD_PC1_LO,
        UPD_DC0_LO,
        UPD_DC_SWAP
    } upd_op_e;

    typedef struct packed {
        rd_src_e src;
        upd_op_e upd;
        logic    long_cyc;
    } cmd_ctl_t;

    // Array content: a fixed affine pattern of the word index.
    function automatic logic [DATA_W-1:0] fill_byte(input int unsigned idx);
        logic [31:0] t;
        t = idx * 32'd37 + 32'd11;
        return t[DATA_W-1:0];
    endfunction

    // Window test done in one extra bit so base+size cannot wrap.
    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W:0]   lo,
                                       input logic [ADDR_W:0]   hi);
        logic [ADDR_W:0] ax;
        ax = {1'b0, a};
        return (ax >= lo) && (ax < hi);
    endfunction

endpackage

// File: rtl/mat_cmd_decode.sv
module mat_cmd_decode
    import mat_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output cmd_ctl_t          ctl
);

    always_comb begin
        ctl.src      = SRC_NONE;
        ctl.upd      = UPD_NONE;
        ctl.long_cyc = 1'b1;
        unique case (code)
            5'h00: begin
                ctl.src = SRC_PC0_MEM;
                ctl.upd = UPD_PC0_INC;
            end
            5'h01: begin
                ctl.src = SRC_PC0_MEM;
                ctl.upd = UPD_PC0_REL;
            end
            5'h02: begin
                ctl.src = SRC_DC0_MEM;
                ctl.upd = UPD_DC0_INC;
            end
            5'h14: ctl.upd = UPD_PC0_HI;
            5'h15: ctl.upd = UPD_PC1_HI;
            5'h16: ctl.upd = UPD_DC0_HI;
            5'h17: ctl.upd = UPD_PC0_LO;
            5'h18: ctl.upd = UPD_PC1_LO;
            5'h19: ctl.upd = UPD_DC0_LO;
            5'h1D: ctl.upd = UPD_DC_SWAP;
            5'h1E: ctl.src = SRC_PC0_LO;
            5'h1F: ctl.src = SRC_PC0_HI;
            default: ;
        endcase
        // Codes that are short, or may run short, carry a cleared tag.
        unique case (code)
            5'h00, 5'h03, 5'h04, 5'h0D, 5'h1C, 5'h1D: ctl.long_cyc = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/mat_addr_regs.sv
module mat_addr_regs
    import mat_pkg::*;
#(
    parameter bit HAS_DC1 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  upd_op_e           upd,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] pc0_q,
    output logic [ADDR_W-1:0] pc1_q,
    output logic [ADDR_W-1:0] dc0_q,
    output logic [ADDR_W-1:0] dc1_q,
    output logic [ADDR_W-1:0] pc0_n,
    output logic [ADDR_W-1:0] dc0_n
);

    localparam int HALF = ADDR_W / 2;

    logic [ADDR_W-1:0] pc1_n;
    logic [ADDR_W-1:0] dc1_n;
    logic [ADDR_W-1:0] rel_off;

    assign rel_off = {{(ADDR_W-DATA_W){bus_in[DATA_W-1]}}, bus_in};

    always_comb begin
        pc0_n = pc0_q;
        pc1_n = pc1_q;
        dc0_n = dc0_q;
        dc1_n = dc1_q;
        if (apply) begin
            unique case (upd)
                UPD_PC0_INC: pc0_n = pc0_q + 1'b1;
                UPD_PC0_REL: pc0_n = pc0_q + rel_off;
                UPD_DC0_INC: dc0_n = dc0_q + 1'b1;
                UPD_PC0_HI:  pc0_n = {bus_in, pc0_q[HALF-1:0]};
                UPD_PC1_HI:  pc1_n = {bus_in, pc1_q[HALF-1:0]};
                UPD_DC0_HI:  dc0_n = {bus_in, dc0_q[HALF-1:0]};
                UPD_PC0_LO:  pc0_n = {pc0_q[ADDR_W-1:HALF], bus_in};
                UPD_PC1_LO:  pc1_n = {pc1_q[ADDR_W-1:HALF], bus_in};
                UPD_DC0_LO:  dc0_n = {dc0_q[ADDR_W-1:HALF], bus_in};
                UPD_DC_SWAP: begin
                    if (HAS_DC1) begin
                        dc0_n = dc1_q;
                        dc1_n = dc0_q;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc0_q <= '0;
            pc1_q <= '0;
            dc0_q <= '0;
        end else begin
            pc0_q <= pc0_n;
            pc1_q <= pc1_n;
            dc0_q <= dc0_n;
        end
    end

    generate
        if (HAS_DC1) begin : g_dc1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dc1_q <= '0;
                else        dc1_q <= dc1_n;
            end
        end else begin : g_no_dc1
            assign dc1_q = '0;
        end
    endgenerate

endmodule

// File: rtl/mat_window_mem.sv
module mat_window_mem
    import mat_pkg::*;
#(
    parameter int unsigned BASE = 16'h0400,
    parameter int unsigned SIZE = 64
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              hit_a,
    output logic              hit_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);

    localparam int IW = (SIZE > 1) ? $clog2(SIZE) : 1;
    localparam logic [ADDR_W:0] LO_W = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] HI_W = (ADDR_W+1)'(BASE + SIZE);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    logic [DATA_W-1:0] mem [SIZE];
    logic [ADDR_W-1:0] off_a;
    logic [ADDR_W-1:0] off_b;
    logic [IW-1:0]     idx_a;
    logic [IW-1:0]     idx_b;

    generate
        for (genvar i = 0; i < int'(SIZE); i++) begin : g_word
            assign mem[i] = fill_byte(i);
        end
    endgenerate

    assign off_a = addr_a - BASE_A;
    assign off_b = addr_b - BASE_A;
    assign idx_a = off_a[IW-1:0];
    assign idx_b = off_b[IW-1:0];

    assign hit_a = in_window(addr_a, LO_W, HI_W);
    assign hit_b = in_window(addr_b, LO_W, HI_W);

    assign rd_a = hit_a ? mem[idx_a] : '0;
    assign rd_b = hit_b ? mem[idx_b] : '0;

endmodule

// File: rtl/mem_addr_tracker.sv
module mem_addr_tracker
    import mat_pkg::*;
#(
    parameter int unsigned BASE    = 16'h0400,
    parameter int unsigned SIZE    = 64,
    parameter bit          HAS_DC1 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        cmd_code,
    input  logic              cmd_valid,
    inout  wire  [7:0]        data_bus,
    output logic              bus_drive,
    output logic              long_cyc,
    output logic [15:0]       pc0_o,
    output logic [15:0]       pc1_o,
    output logic [15:0]       dc0_o,
    output logic [15:0]       dc1_o
);

    localparam logic [ADDR_W:0] LO_W = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] HI_W = (ADDR_W+1)'(BASE + SIZE);

    bus_state_e        state_q, state_d;
    cmd_ctl_t          dec_ctl;
    cmd_ctl_t          cur_ctl_q;
    logic [CODE_W-1:0] cur_code_q;
    logic [DATA_W-1:0] bus_in;
    logic [DATA_W-1:0] bus_out;
    logic [ADDR_W-1:0] pc0_n, dc0_n;
    logic              hit_pc0, hit_dc0;
    logic [DATA_W-1:0] rd_pc0, rd_dc0;
    logic              exec_on;
    logic              own_next;

    assign bus_in  = data_bus;
    assign exec_on = (state_q != ST_IDLE);

    mat_cmd_decode u_dec (
        .code (cmd_code),
        .ctl  (dec_ctl)
    );

    mat_addr_regs #(.HAS_DC1(HAS_DC1)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply  (exec_on),
        .upd    (cur_ctl_q.upd),
        .bus_in (bus_in),
        .pc0_q  (pc0_o),
        .pc1_q  (pc1_o),
        .dc0_q  (dc0_o),
        .dc1_q  (dc1_o),
        .pc0_n  (pc0_n),
        .dc0_n  (dc0_n)
    );

    mat_window_mem #(.BASE(BASE), .SIZE(SIZE)) u_mem (
        .addr_a (pc0_o),
        .addr_b (dc0_o),
        .hit_a  (hit_pc0),
        .hit_b  (hit_dc0),
        .rd_a   (rd_pc0),
        .rd_b   (rd_dc0)
    );

    // Ownership for the incoming code is judged on post-update counters.
    always_comb begin
        unique case (dec_ctl.src)
            SRC_PC0_MEM, SRC_PC0_LO, SRC_PC0_HI: own_next = in_window(pc0_n, LO_W, HI_W);
            SRC_DC0_MEM:                         own_next = in_window(dc0_n, LO_W, HI_W);
            default:                             own_next = 1'b0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DRIVE, ST_LISTEN: begin
                if (cmd_valid) state_d = own_next ? ST_DRIVE : ST_LISTEN;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and command latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_ctl_q  <= '{src: SRC_NONE, upd: UPD_NONE, long_cyc: 1'b0};
            cur_code_q <= 5'h1C;
        end else begin
            state_q <= state_d;
            if (cmd_valid) begin
                cur_ctl_q  <= dec_ctl;
                cur_code_q <= cmd_code;
            end
        end
    end

    // Output logic.
    always_comb begin
        bus_drive = 1'b0;
        bus_out   = '0;
        long_cyc  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRIVE: begin
                bus_drive = 1'b1;
                long_cyc  = cur_ctl_q.long_cyc;
                unique case (cur_ctl_q.src)
                    SRC_PC0_MEM: bus_out = rd_pc0;
                    SRC_DC0_MEM: bus_out = rd_dc0;
                    SRC_PC0_LO:  bus_out = pc0_o[7:0];
                    SRC_PC0_HI:  bus_out = pc0_o[15:8];
                    default:     bus_out = '0;
                endcase
            end
            ST_LISTEN: long_cyc = cur_ctl_q.long_cyc;
            default: ;
        endcase
    end

    assign data_bus = bus_drive ? bus_out : 8'hzz;

endmodule

// File: rtl/mat_bus_checker.sv
module mat_bus_checker
    import mat_pkg::*;
#(
    parameter bit HAS_DC1 = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_e        state_q,
    input logic [CODE_W-1:0] cur_code,
    input logic              bus_drive,
    input logic              long_cyc,
    input logic              hit_pc0,
    input logic              hit_dc0,
    input logic [15:0]       pc0,
    input logic [15:0]       pc1,
    input logic [15:0]       dc0,
    input logic [15:0]       dc1
);

    logic exec_on;
    logic is_nop;
    assign exec_on = (state_q != ST_IDLE);
    assign is_nop  = (cur_code >= 5'h03 && cur_code <= 5'h13) ||
                     cur_code == 5'h1A || cur_code == 5'h1B || cur_code == 5'h1C;

    // R2: nothing moves while no command executes
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_on |=> (pc0 == $past(pc0) && pc1 == $past(pc1) &&
                      dc0 == $past(dc0) && dc1 == $past(dc1)));

    // R3: fetch advances PC0 by one
    assert_fetch_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_on && cur_code == 5'h00) |=> pc0 == $past(pc0) + 16'd1);

    // R5: data read advances DC0 by one
    assert_dc0_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_on && cur_code == 5'h02) |=> dc0 == $past(dc0) + 16'd1);

    // R8: exchange of the data counters
    assert_dc_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_DC1 && exec_on && cur_code == 5'h1D) |=>
            (dc0 == $past(dc1) && dc1 == $past(dc0)));

    // R9: reading PC0 bytes leaves the counters alone
    assert_pc0_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_on && (cur_code == 5'h1E || cur_code == 5'h1F)) |=> pc0 == $past(pc0));

    // R10: the bus is driven only for an owned read code
    assert_drive_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> ((cur_code == 5'h02 && hit_dc0) ||
                       ((cur_code == 5'h00 || cur_code == 5'h01 ||
                         cur_code == 5'h1E || cur_code == 5'h1F) && hit_pc0)));

    // R11: unused codes change nothing and keep the bus released
    assert_nop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_on && is_nop) |=> (pc0 == $past(pc0) && pc1 == $past(pc1) &&
                                 dc0 == $past(dc0) && dc1 == $past(dc1)));

    assert_nop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_on && is_nop) |-> !bus_drive);

    // R13: cycle tag cleared outside execution
    assert_tag_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_on |-> !long_cyc);

endmodule

bind mem_addr_tracker mat_bus_checker #(.HAS_DC1(HAS_DC1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cur_code  (cur_code_q),
    .bus_drive (bus_drive),
    .long_cyc  (long_cyc),
    .hit_pc0   (hit_pc0),
    .hit_dc0   (hit_dc0),
    .pc0       (pc0_o),
    .pc1       (pc1_o),
    .dc0       (dc0_o),
    .dc1       (dc1_o)
);

// File: tb/mem_addr_tracker_test.sv
module mem_addr_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cmd_code = 5'h1C;
    logic        cmd_valid = 1'b0;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_val = 8'h00;
    wire  [7:0]  data_bus;
    logic        bus_drive, long_cyc;
    logic [15:0] pc0_o, pc1_o, dc0_o, dc1_o;

    int n_checks = 0;
    int n_fail   = 0;

    assign data_bus = tb_drv ? tb_val : 8'hzz;

    always #5 clk = ~clk;

    mem_addr_tracker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_code  (cmd_code),
        .cmd_valid (cmd_valid),
        .data_bus  (data_bus),
        .bus_drive (bus_drive),
        .long_cyc  (long_cyc),
        .pc0_o     (pc0_o),
        .pc1_o     (pc1_o),
        .dc0_o     (dc0_o),
        .dc1_o     (dc1_o)
    );

    localparam logic [15:0] WBASE = 16'h0400;

    function automatic logic [7:0] want_byte(input logic [15:0] addr);
        logic [31:0] t;
        t = 32'(addr - WBASE) * 32'd37 + 32'd11;
        return t[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // One full bus cycle: present, execute (optionally drive), settle.
    task automatic bus_cycle(input logic [4:0] code, input bit ext, input logic [7:0] ext_val,
                             output bit drv, output logic [7:0] bv, output bit lg);
        @(negedge clk);
        cmd_code  = code;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        tb_drv    = ext;
        tb_val    = ext_val;
        #1;
        drv = bus_drive;
        bv  = data_bus;
        lg  = long_cyc;
        @(negedge clk);
        tb_drv = 1'b0;
    endtask

    task automatic load(input logic [4:0] code, input logic [7:0] val);
        bit d, l;
        logic [7:0] b;
        bus_cycle(code, 1'b1, val, d, b, l);
    endtask

    task automatic set_pc0(input logic [15:0] v);
        load(5'h14, v[15:8]);
        load(5'h17, v[7:0]);
    endtask

    task automatic set_dc0(input logic [15:0] v);
        load(5'h16, v[15:8]);
        load(5'h19, v[7:0]);
    endtask

    task automatic t_reset;
        check_eq("R1 pc0", pc0_o, 16'h0000);
        check_eq("R1 pc1", pc1_o, 16'h0000);
        check_eq("R1 dc0", dc0_o, 16'h0000);
        check_eq("R1 dc1", dc1_o, 16'h0000);
        check_eq("R1 bus_drive", 16'(bus_drive), 16'h0);
        check_eq("R1 long_cyc", 16'(long_cyc), 16'h0);
    endtask

    task automatic t_loads;
        bit d, l;
        logic [7:0] b;
        bus_cycle(5'h14, 1'b1, 8'h04, d, b, l);
        check_eq("R13 tag long on 0x14", 16'(l), 16'h1);
        check_eq("R6 pc0 high", pc0_o, 16'h0400);
        load(5'h17, 8'h10);
        check_eq("R7 pc0 low", pc0_o, 16'h0410);
        load(5'h15, 8'hAB);
        load(5'h18, 8'hCD);
        check_eq("R6/R7 pc1", pc1_o, 16'hABCD);
        check_eq("R6 pc0 untouched by pc1 load", pc0_o, 16'h0410);
        load(5'h16, 8'h04);
        load(5'h19, 8'h3E);
        check_eq("R7 dc0", dc0_o, 16'h043E);
        check_eq("R6 pc1 untouched by dc0 load", pc1_o, 16'hABCD);
    endtask

    task automatic t_fetch;
        bit d, l;
        logic [7:0] b;
        bus_cycle(5'h00, 1'b0, 8'h00, d, b, l);
        check_eq("R3 fetch drives", 16'(d), 16'h1);
        check_eq("R12 fetch byte", 16'(b), 16'(want_byte(16'h0410)));
        check_eq("R13 tag short on 0x00", 16'(l), 16'h0);
        check_eq("R3 pc0 incremented", pc0_o, 16'h0411);
    endtask

    task automatic t_read_pc;
        bit d, l;
        logic [7:0] b;
        bus_cycle(5'h1E, 1'b0, 8'h00, d, b, l);
        check_eq("R9 low byte drive", 16'(d), 16'h1);
        check_eq("R9 low byte", 16'(b), 16'h0011);
        bus_cycle(5'h1F, 1'b0, 8'h00, d, b, l);
        check_eq("R9 high byte", 16'(b), 16'h0004);
        check_eq("R9 pc0 unchanged", pc0_o, 16'h0411);
    endtask

    task automatic t_branch;
        bit d, l;
        logic [7:0] b;
        bus_cycle(5'h01, 1'b0, 8'h00, d, b, l);
        check_eq("R4 branch byte", 16'(b), 16'(want_byte(16'h0411)));
        check_eq("R4 negative offset", pc0_o, 16'h0411 - 16'd128);
        set_pc0(16'h0402);
        bus_cycle(5'h01, 1'b0, 8'h00, d, b, l);
        check_eq("R4 positive offset", pc0_o, 16'h0402 + 16'(want_byte(16'h0402)));
    endtask

    task automatic t_window;
        bit d, l;
        logic [7:0] b;
        set_pc0(16'h03FF);
        bus_cycle(5'h00, 1'b1, 8'h77, d, b, l);
        check_eq("R10 below window no drive", 16'(d), 16'h0);
        check_eq("R10 non-owner still increments", pc0_o, 16'h0400);
        bus_cycle(5'h00, 1'b0, 8'h00, d, b, l);
        check_eq("R10 lower edge owned", 16'(d), 16'h1);
        check_eq("R12 first word", 16'(b), 16'h000B);
        set_pc0(16'h043F);
        bus_cycle(5'h1E, 1'b0, 8'h00, d, b, l);
        check_eq("R10 last word owned", 16'(d), 16'h1);
        set_pc0(16'h0440);
        bus_cycle(5'h1F, 1'b1, 8'h55, d, b, l);
        check_eq("R10 upper edge not owned", 16'(d), 16'h0);
        set_pc0(16'h0390);
        bus_cycle(5'h01, 1'b1, 8'h05, d, b, l);
        check_eq("R10 external offset used", pc0_o, 16'h0395);
    endtask

    task automatic t_dc0;
        bit d, l;
        logic [7:0] b;
        set_dc0(16'h043E);
        bus_cycle(5'h02, 1'b0, 8'h00, d, b, l);
        check_eq("R5 read byte", 16'(b), 16'(want_byte(16'h043E)));
        check_eq("R5 dc0 inc", dc0_o, 16'h043F);
        bus_cycle(5'h02, 1'b0, 8'h00, d, b, l);
        check_eq("R5 second read byte", 16'(b), 16'(want_byte(16'h043F)));
        bus_cycle(5'h02, 1'b1, 8'h99, d, b, l);
        check_eq("R10 dc0 past window no drive", 16'(d), 16'h0);
        check_eq("R5 dc0 inc non-owner", dc0_o, 16'h0441);
    endtask

    task automatic t_wrap;
        bit d, l;
        logic [7:0] b;
        set_pc0(16'hFFFF);
        bus_cycle(5'h00, 1'b1, 8'h00, d, b, l);
        check_eq("R3 pc0 wrap", pc0_o, 16'h0000);
        set_dc0(16'hFFFF);
        bus_cycle(5'h02, 1'b1, 8'h00, d, b, l);
        check_eq("R5 dc0 wrap", dc0_o, 16'h0000);
    endtask

    task automatic t_swap;
        bit d, l;
        logic [7:0] b;
        set_dc0(16'h1234);
        bus_cycle(5'h1D, 1'b0, 8'h00, d, b, l);
        check_eq("R13 tag short on 0x1D", 16'(l), 16'h0);
        check_eq("R8 dc0 after swap", dc0_o, 16'h0000);
        check_eq("R8 dc1 after swap", dc1_o, 16'h1234);
        bus_cycle(5'h1D, 1'b0, 8'h00, d, b, l);
        check_eq("R8 dc0 swapped back", dc0_o, 16'h1234);
        check_eq("R8 dc1 swapped back", dc1_o, 16'h0000);
    endtask

    task automatic t_nop;
        bit d, l;
        logic [7:0] b;
        logic [4:0] codes [7] = '{5'h03, 5'h04, 5'h0A, 5'h13, 5'h1A, 5'h1B, 5'h1C};
        logic [15:0] s0, s1, s2, s3;
        set_pc0(16'h0408);
        s0 = pc0_o; s1 = pc1_o; s2 = dc0_o; s3 = dc1_o;
        for (int i = 0; i < 7; i++) begin
            bus_cycle(codes[i], 1'b1, 8'hEE, d, b, l);
            check_eq("R11 no drive", 16'(d), 16'h0);
            check_eq("R11 pc0 held", pc0_o, s0);
            check_eq("R11 pc1 held", pc1_o, s1);
            check_eq("R11 dc0 held", dc0_o, s2);
            check_eq("R11 dc1 held", dc1_o, s3);
            if (codes[i] == 5'h0A) check_eq("R13 tag long on 0x0A", 16'(l), 16'h1);
            if (codes[i] == 5'h1C) check_eq("R13 tag short on 0x1C", 16'(l), 16'h0);
            if (codes[i] == 5'h04) check_eq("R13 tag short on 0x04", 16'(l), 16'h0);
        end
    endtask

    task automatic t_back_to_back;
        set_pc0(16'h0400);
        @(negedge clk);
        cmd_code  = 5'h14;
        cmd_valid = 1'b0;
        tb_drv    = 1'b1;
        tb_val    = 8'hEE;
        @(negedge clk);
        @(negedge clk);
        tb_drv = 1'b0;
        check_eq("R2 strobe low ignored", pc0_o, 16'h0400);
        cmd_code  = 5'h00;
        cmd_valid = 1'b1;
        @(negedge clk);
        #1;
        check_eq("R2 first fetch byte", 16'(data_bus), 16'(want_byte(16'h0400)));
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check_eq("R2 second fetch byte", 16'(data_bus), 16'(want_byte(16'h0401)));
        check_eq("R2 first update visible", pc0_o, 16'h0401);
        @(negedge clk);
        check_eq("R2 two increments", pc0_o, 16'h0402);
        check_eq("R2 idle after burst", 16'(bus_drive), 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_fetch();
        t_read_pc();
        t_branch();
        t_window();
        t_dc0();
        t_wrap();
        t_swap();
        t_nop();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule